// File: doc/BRIEF.md
# Multi-Carrier PWM Generator with Dead Time

This block turns a set of programmable registers into several groups of PWM signals. A timebase tick comes either from an internal clock divider or from an external tick input. The tick drives one carrier counter per channel. Each counter produces a sawtooth or a triangle between zero and a programmable peak. Each channel feeds a bank of window comparators, and every window yields a high-side signal and a low-side complement. An automatic dead gap separates the two sides of each pair.

The channels run from the same tick, but each channel's counter is released a programmable number of ticks after start. This gives the carriers fixed phase offsets, as multi-carrier modulation needs. Threshold writes go to shadow copies. The comparators take them up only when their carrier returns to zero, so the current period is never cut short. A fault input, or a cleared run bit, immediately forces every output to a parameterised safe level and returns all counters to zero.

Top module: `pwm_multicarrier`

## Requirements
- R1: With the internal source selected and the generator running, `tick_out` pulses once every divide+1 clock cycles. The divide value sits at word address 1. The first pulse comes divide cycles after the run bit takes effect.
- R2: When control bit 1 is set, the tick follows `ext_tick` in the same cycle and the divider plays no part.
- R3: When control bit 2 is 0 (sawtooth), each channel counts 0,1,…,peak on successive ticks and then returns to 0. The peak value sits at word address 2.
- R4: When control bit 2 is 1 (triangle), the counter runs 0 up to peak and back down to 1, then starts again at 0. One period is 2·peak ticks.
- R5: Output k (k = channel·outputs-per-channel + index) has a lower threshold at address 16+2k and an upper threshold at address 17+2k. Its window is true while lower ≤ carrier < upper.
- R6: The high side follows the window one clock later. After every window edge, both sides stay low for dead clock cycles, where the dead value sits at address 3. A window state that lasts L clocks drives its side high for max(L−dead, 0) clocks. The two sides are never high together.
- R7: Channel c's counter stays at zero for the number of ticks held at address 8+c. It then advances, so its outputs lag channel 0 by that many clocks when the tick comes every clock.
- R8: A threshold write takes effect only when the carrier next returns to zero, or at once while the generator is stopped.
- R9: While `fault` is high or the run bit (control bit 0) is clear, every output equals `STOP_LEVEL` in the same cycle, and the divider, delays and counters return to zero. After release, each pair restarts with its high side low for one clock.
- R10: Every register reads back on `reg_rdata` in the same cycle, truncated to its field width. The widths are: control 3 bits, divide 16, peak 16, dead 8, delays 16, thresholds 16.
- R11: A synchronous active-high reset clears every register and drives all outputs to `STOP_LEVEL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_tick | input | 1 | External timebase tick |
| fault | input | 1 | Forces all outputs to the stop level while high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| tick_out | output | 1 | Timebase tick in use |
| pwm_hs | output | N_CH·N_OUT | High-side PWM outputs |
| pwm_ls | output | N_CH·N_OUT | Low-side complementary outputs |

## Verification
Some results appear in the same cycle as their cause: `tick_out`, register read data, and the forced stop level on fault or stop. Other results need one clock edge: a register write or a run-bit change, which then moves the carrier on the next tick. A window edge reaches the high side one clock after the carrier crosses a threshold, and the opposite side waits a further dead cycles. All checks sample on the falling clock edge, and each expected index counts these registers. Examples are the first high side at sample 3 for a lower threshold of 2, and the restart pattern in the first two cycles after a fault. Duty checks count over whole carrier periods after a settling time, so the phase of the window does not matter.

// File: rtl/pwmgen_pkg.sv
`timescale 1ns/1ps
package pwmgen_pkg;

    typedef enum logic {
        CAR_SAW = 1'b0,
        CAR_TRI = 1'b1
    } car_mode_e;

    // control word: bit0 run, bit1 external tick, bit2 carrier shape
    typedef struct packed {
        car_mode_e mode;
        logic      ext;
        logic      run;
    } ctrl_t;

    localparam int REG_AW = 6;
    localparam int REG_DW = 32;

    localparam logic [REG_AW-1:0] ADR_CTRL = 6'd0;
    localparam logic [REG_AW-1:0] ADR_DIV  = 6'd1;
    localparam logic [REG_AW-1:0] ADR_PEAK = 6'd2;
    localparam logic [REG_AW-1:0] ADR_DEAD = 6'd3;
    localparam logic [REG_AW-1:0] ADR_DLY0 = 6'd8;   // up to 8 channels
    localparam logic [REG_AW-1:0] ADR_TH0  = 6'd16;  // up to 24 outputs

    function automatic logic in_window(input logic [31:0] v,
                                       input logic [31:0] lo,
                                       input logic [31:0] hi);
        return (v >= lo) && (v < hi);
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
`timescale 1ns/1ps
module pwm_prescaler #(
    parameter int DIVW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            halt,
    input  logic            use_ext,
    input  logic            ext_tick,
    input  logic [DIVW-1:0] div,
    output logic            tick
);
    logic [DIVW-1:0] cnt_q;
    logic            int_tick;

    assign int_tick = (cnt_q >= div);

    always_ff @(posedge clk) begin
        if (rst || halt || use_ext) begin
            cnt_q <= '0;
        end else if (int_tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = !halt && (use_ext ? ext_tick : int_tick);

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        (tick && !use_ext && div != '0) |=> (!tick || div == '0 || use_ext)); // R1

endmodule

// File: rtl/pwm_carrier.sv
`timescale 1ns/1ps
module pwm_carrier #(
    parameter int CW = 16,
    parameter int NO = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     halt,
    input  logic                     tick,
    input  pwmgen_pkg::car_mode_e    mode,
    input  logic [CW-1:0]            peak,
    input  logic [CW-1:0]            delay,
    input  logic [NO-1:0][CW-1:0]    lo_sh,
    input  logic [NO-1:0][CW-1:0]    hi_sh,
    output logic [NO-1:0]            win
);
    logic [CW-1:0]         cnt_q, cnt_nxt, dly_q;
    logic                  down_q, down_nxt;
    logic                  en, adv, load;
    logic [NO-1:0][CW-1:0] lo_act, hi_act;

    assign en   = (dly_q >= delay);
    assign adv  = tick && en;

    always_comb begin
        cnt_nxt  = cnt_q;
        down_nxt = down_q;
        if (mode == pwmgen_pkg::CAR_SAW) begin
            down_nxt = 1'b0;
            cnt_nxt  = (cnt_q >= peak) ? '0 : cnt_q + 1'b1;
        end else if (peak == '0) begin
            down_nxt = 1'b0;
            cnt_nxt  = '0;
        end else if (!down_q) begin
            if (cnt_q >= peak) begin
                down_nxt = 1'b1;
                cnt_nxt  = peak - 1'b1;
            end else begin
                cnt_nxt  = cnt_q + 1'b1;
            end
        end else if (cnt_q == '0) begin
            down_nxt = 1'b0;
            cnt_nxt  = {{(CW-1){1'b0}}, 1'b1};
        end else begin
            cnt_nxt  = cnt_q - 1'b1;
        end
    end

    assign load = halt || (adv && cnt_nxt == '0);

    always_ff @(posedge clk) begin
        if (rst || halt) begin
            cnt_q  <= '0;
            down_q <= 1'b0;
            dly_q  <= '0;
        end else begin
            if (tick && !en) begin
                dly_q <= dly_q + 1'b1;
            end
            if (adv) begin
                cnt_q  <= cnt_nxt;
                down_q <= down_nxt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_act <= '0;
            hi_act <= '0;
        end else if (load) begin
            lo_act <= lo_sh;
            hi_act <= hi_sh;
        end
    end

    generate
        for (genvar o = 0; o < NO; o++) begin : g_cmp
            assign win[o] = !halt && pwmgen_pkg::in_window(32'(cnt_q),
                                                            32'(lo_act[o]),
                                                            32'(hi_act[o]));
        end
    endgenerate

    AST_PEAK_BOUND: assert property (@(posedge clk) disable iff (rst)
        (!halt && cnt_q <= peak) |=> (cnt_q <= $past(peak))); // R3

    AST_TRI_TURN: assert property (@(posedge clk) disable iff (rst)
        (mode == pwmgen_pkg::CAR_TRI && adv && !halt && peak != '0 && cnt_q == peak && !down_q)
        |=> (cnt_q == $past(peak) - 1'b1)); // R4

    AST_HOLD_DELAY: assert property (@(posedge clk) disable iff (rst)
        (!en && !halt) |=> $stable(cnt_q)); // R7

    AST_LOAD_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (lo_act != $past(lo_act) || hi_act != $past(hi_act)) |-> (cnt_q == '0)); // R8

endmodule

// File: rtl/pwm_deadtime.sv
`timescale 1ns/1ps
module pwm_deadtime #(
    parameter int DTW = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clear,
    input  logic           raw,
    input  logic [DTW-1:0] dead,
    output logic           hs,
    output logic           ls
);
    logic           raw_q;
    logic [DTW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            raw_q <= 1'b0;
            gap_q <= '0;
        end else begin
            raw_q <= raw;
            if (raw != raw_q) begin
                gap_q <= dead;
            end else if (gap_q != '0) begin
                gap_q <= gap_q - 1'b1;
            end
        end
    end

    assign hs = raw_q && (gap_q == '0);
    assign ls = !raw_q && (gap_q == '0);

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(hs && ls)); // R6

    AST_GAP_AFTER_EDGE: assert property (@(posedge clk) disable iff (rst)
        (raw_q != $past(raw_q) && $past(dead) != '0 && !$past(clear)) |-> (!hs && !ls)); // R6

endmodule

// File: rtl/pwm_multicarrier.sv
`timescale 1ns/1ps
module pwm_multicarrier
    import pwmgen_pkg::*;
#(
    parameter int   N_CH       = 2,
    parameter int   N_OUT      = 2,
    parameter int   CW         = 16,
    parameter int   DIVW       = 16,
    parameter int   DTW        = 8,
    parameter logic STOP_LEVEL = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ext_tick,
    input  logic                    fault,
    input  logic                    reg_wr,
    input  logic [REG_AW-1:0]       reg_addr,
    input  logic [REG_DW-1:0]       reg_wdata,
    output logic [REG_DW-1:0]       reg_rdata,
    output logic                    tick_out,
    output logic [N_CH*N_OUT-1:0]   pwm_hs,
    output logic [N_CH*N_OUT-1:0]   pwm_ls
);
    localparam int NT = N_CH * N_OUT;

    ctrl_t                 ctrl_q;
    logic [DIVW-1:0]       div_q;
    logic [CW-1:0]         peak_q;
    logic [DTW-1:0]        dead_q;
    logic [N_CH-1:0][CW-1:0] dly_q;
    logic [NT-1:0][CW-1:0] lo_q, hi_q;

    logic                  halt, tick;
    logic [NT-1:0]         raw, hs_i, ls_i;
    logic                  unused_wbits;

    assign unused_wbits = ^reg_wdata;

    // register writes
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            div_q  <= '0;
            peak_q <= '0;
            dead_q <= '0;
            dly_q  <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADR_CTRL) ctrl_q <= ctrl_t'(reg_wdata[2:0]);
            if (reg_addr == ADR_DIV)  div_q  <= reg_wdata[DIVW-1:0];
            if (reg_addr == ADR_PEAK) peak_q <= reg_wdata[CW-1:0];
            if (reg_addr == ADR_DEAD) dead_q <= reg_wdata[DTW-1:0];
            for (int c = 0; c < N_CH; c++) begin
                if (reg_addr == ADR_DLY0 + REG_AW'(c)) dly_q[c] <= reg_wdata[CW-1:0];
            end
            for (int k = 0; k < NT; k++) begin
                if (reg_addr == ADR_TH0 + REG_AW'(2*k))     lo_q[k] <= reg_wdata[CW-1:0];
                if (reg_addr == ADR_TH0 + REG_AW'(2*k + 1)) hi_q[k] <= reg_wdata[CW-1:0];
            end
        end
    end

    // register reads
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADR_CTRL) reg_rdata[2:0]      = ctrl_q;
        if (reg_addr == ADR_DIV)  reg_rdata[DIVW-1:0] = div_q;
        if (reg_addr == ADR_PEAK) reg_rdata[CW-1:0]   = peak_q;
        if (reg_addr == ADR_DEAD) reg_rdata[DTW-1:0]  = dead_q;
        for (int c = 0; c < N_CH; c++) begin
            if (reg_addr == ADR_DLY0 + REG_AW'(c)) reg_rdata[CW-1:0] = dly_q[c];
        end
        for (int k = 0; k < NT; k++) begin
            if (reg_addr == ADR_TH0 + REG_AW'(2*k))     reg_rdata[CW-1:0] = lo_q[k];
            if (reg_addr == ADR_TH0 + REG_AW'(2*k + 1)) reg_rdata[CW-1:0] = hi_q[k];
        end
    end

    assign halt = !ctrl_q.run || fault;

    pwm_prescaler #(.DIVW(DIVW)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .halt     (halt),
        .use_ext  (ctrl_q.ext),
        .ext_tick (ext_tick),
        .div      (div_q),
        .tick     (tick)
    );

    generate
        for (genvar c = 0; c < N_CH; c++) begin : g_ch
            pwm_carrier #(.CW(CW), .NO(N_OUT)) u_car (
                .clk   (clk),
                .rst   (rst),
                .halt  (halt),
                .tick  (tick),
                .mode  (ctrl_q.mode),
                .peak  (peak_q),
                .delay (dly_q[c]),
                .lo_sh (lo_q[c*N_OUT +: N_OUT]),
                .hi_sh (hi_q[c*N_OUT +: N_OUT]),
                .win   (raw[c*N_OUT +: N_OUT])
            );
        end
        for (genvar k = 0; k < NT; k++) begin : g_dt
            pwm_deadtime #(.DTW(DTW)) u_dt (
                .clk   (clk),
                .rst   (rst),
                .clear (halt),
                .raw   (raw[k]),
                .dead  (dead_q),
                .hs    (hs_i[k]),
                .ls    (ls_i[k])
            );
        end
    endgenerate

    assign tick_out = tick;
    assign pwm_hs   = halt ? {NT{STOP_LEVEL}} : hs_i;
    assign pwm_ls   = halt ? {NT{STOP_LEVEL}} : ls_i;

    AST_RESTART_LOW: assert property (@(posedge clk) disable iff (rst)
        ($past(fault) && !fault && ctrl_q.run) |-> (pwm_hs == '0)); // R9

endmodule

// File: tb/pwm_multicarrier_test.sv
`timescale 1ns/1ps
module pwm_multicarrier_test;
    import pwmgen_pkg::*;

    localparam int NT = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_tick = 1'b0;
    logic        fault = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tick_out;
    logic [NT-1:0] pwm_hs, pwm_ls;

    int n_tot = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pwm_multicarrier uut (
        .clk(clk), .rst(rst), .ext_tick(ext_tick), .fault(fault),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tick_out(tick_out), .pwm_hs(pwm_hs), .pwm_ls(pwm_ls)
    );

    typedef struct packed {
        logic       tri_m;
        logic [7:0] per;
        logic [7:0] lo;
        logic [7:0] hi;
        logic [7:0] dt;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{1'b0, 8'd9, 8'd0, 8'd5, 8'd0},
        '{1'b0, 8'd9, 8'd2, 8'd7, 8'd2},
        '{1'b0, 8'd9, 8'd3, 8'd5, 8'd3},
        '{1'b1, 8'd8, 8'd3, 8'd6, 8'd1},
        '{1'b1, 8'd6, 8'd0, 8'd3, 8'd2},
        '{1'b0, 8'd7, 8'd0, 8'd9, 8'd2},
        '{1'b0, 8'd7, 8'd5, 8'd2, 8'd1}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tot++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
    endtask

    // reference: steady counts of high side / low side per period
    task automatic model(input logic m, input int per, input int lo, input int hi, input int dt,
                         output int len, output int hi_n, output int lo_n);
        logic r [0:63];
        int   s;
        int   runl;
        logic cur;
        len = m ? 2*per : per + 1;
        if (len < 1) len = 1;
        for (int i = 0; i < len; i++) begin
            int v;
            v = (!m || i <= per) ? i : 2*per - i;
            r[i] = (v >= lo) && (v < hi);
        end
        hi_n = 0;
        lo_n = 0;
        s = -1;
        for (int i = 0; i < len; i++) begin
            if (s < 0 && r[i] != r[(i + len - 1) % len]) s = i;
        end
        if (s < 0) begin
            if (r[0]) hi_n = len; else lo_n = len;
        end else begin
            cur  = r[s];
            runl = 0;
            for (int j = 0; j < len; j++) begin
                int ix;
                ix = (s + j) % len;
                if (r[ix] == cur) begin
                    runl++;
                end else begin
                    if (cur) hi_n += (runl > dt) ? runl - dt : 0;
                    else     lo_n += (runl > dt) ? runl - dt : 0;
                    cur  = r[ix];
                    runl = 1;
                end
            end
            if (cur) hi_n += (runl > dt) ? runl - dt : 0;
            else     lo_n += (runl > dt) ? runl - dt : 0;
        end
    endtask

    task automatic measure(input int n, output int nh, output int nl, output int nov);
        nh = 0; nl = 0; nov = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_hs[0]) nh++;
            if (pwm_ls[0]) nl++;
            if ((pwm_hs & pwm_ls) != '0) nov++;
        end
        @(posedge clk);
        #1;
    endtask

    task automatic count_ticks(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tick_out) c++;
        end
    endtask

    task automatic pulse_len(output int l);
        l = 1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (!pwm_hs[0]) break;
            l++;
        end
    endtask

    initial begin
        #2_000_000;
        n_tot++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end

    initial begin
        int v, len, eh, el, mh, ml, mov, c, f0, f2, l1, l2, found;

        // R11: reset state
        step();
        @(negedge clk);
        check("R11", "hs after reset", int'(pwm_hs), 0);
        check("R11", "ls after reset", int'(pwm_ls), 0);
        check("R11", "tick after reset", int'(tick_out), 0);
        @(posedge clk); #1;
        rst = 1'b0;
        rd(ADR_PEAK, v);        check("R11", "peak reset", v, 0);
        rd(ADR_TH0 + 6'd5, v);  check("R11", "threshold reset", v, 0);
        rd(ADR_CTRL, v);        check("R11", "ctrl reset", v, 0);

        // R10: readback with truncation
        wr(ADR_PEAK, 32'h1ABCD);      rd(ADR_PEAK, v);        check("R10", "peak", v, 32'hABCD);
        wr(ADR_DIV, 32'h12345);       rd(ADR_DIV, v);         check("R10", "divide", v, 32'h2345);
        wr(ADR_DEAD, 32'h1FF);        rd(ADR_DEAD, v);        check("R10", "dead", v, 32'hFF);
        wr(ADR_CTRL, 32'hFE);         rd(ADR_CTRL, v);        check("R10", "ctrl", v, 6);
        wr(ADR_DLY0 + 6'd1, 32'h7);   rd(ADR_DLY0 + 6'd1, v); check("R10", "delay1", v, 7);
        wr(ADR_TH0 + 6'd7, 32'h55);   rd(ADR_TH0 + 6'd7, v);  check("R10", "upper th k3", v, 32'h55);
        do_reset();

        // R3 R4 R5 R6: vector table walked by one loop
        for (int k = 0; k < 7; k++) begin
            vec_t t;
            t = VECS[k];
            wr(ADR_CTRL, 32'd0);
            wr(ADR_DIV, 32'd0);
            wr(ADR_PEAK, 32'(t.per));
            wr(ADR_DEAD, 32'(t.dt));
            wr(ADR_TH0, 32'(t.lo));
            wr(ADR_TH0 + 6'd1, 32'(t.hi));
            wr(ADR_CTRL, {29'd0, t.tri_m, 2'b01});
            model(t.tri_m, int'(t.per), int'(t.lo), int'(t.hi), int'(t.dt), len, eh, el);
            repeat (3*len + int'(t.dt) + 4) step();
            measure(4*len, mh, ml, mov);
            check(t.tri_m ? "R4 R5 R6" : "R3 R5 R6", $sformatf("vec%0d high count", k), mh, 4*eh);
            check(t.tri_m ? "R4 R5 R6" : "R3 R5 R6", $sformatf("vec%0d low count", k), ml, 4*el);
            check("R6", $sformatf("vec%0d overlap", k), mov, 0);
        end

        // R1: internal divider
        wr(ADR_CTRL, 32'd0);
        wr(ADR_DIV, 32'd3);
        wr(ADR_CTRL, 32'd1);
        count_ticks(40, c);
        check("R1", "ticks in 40 cycles div3", c, 10);
        @(posedge clk); #1;

        // R2: external tick
        wr(ADR_CTRL, 32'd0);
        wr(ADR_DIV, 32'd0);
        wr(ADR_CTRL, 32'd3);
        fork
            begin
                for (int p = 0; p < 5; p++) begin
                    ext_tick = 1'b1; step();
                    ext_tick = 1'b0; step(); step();
                end
            end
            count_ticks(16, c);
        join
        check("R2", "ticks follow external", c, 5);
        @(posedge clk); #1;

        // R7: staggered release
        do_reset();
        wr(ADR_PEAK, 32'd9);
        wr(ADR_TH0, 32'd2);         wr(ADR_TH0 + 6'd1, 32'd6);
        wr(ADR_TH0 + 6'd4, 32'd2);  wr(ADR_TH0 + 6'd5, 32'd6);
        wr(ADR_DLY0 + 6'd1, 32'd3);
        wr(ADR_CTRL, 32'd1);
        f0 = -1; f2 = -1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (f0 < 0 && pwm_hs[0]) f0 = i;
            if (f2 < 0 && pwm_hs[2]) f2 = i;
        end
        check("R7", "channel0 first high sample", f0, 3);
        check("R7", "channel1 lag", f2 - f0, 3);
        @(posedge clk); #1;

        // R8: shadow threshold load at zero
        do_reset();
        wr(ADR_PEAK, 32'd9);
        wr(ADR_TH0, 32'd0);
        wr(ADR_TH0 + 6'd1, 32'd5);
        wr(ADR_CTRL, 32'd1);
        found = 0;
        for (int i = 0; i < 40 && found == 0; i++) begin
            @(negedge clk);
            if (pwm_hs[0]) found = 1;
        end
        fork
            wr(ADR_TH0 + 6'd1, 32'd8);
            pulse_len(l1);
        join
        check("R8", "pulse during write", l1, 5);
        found = 0;
        for (int i = 0; i < 40 && found == 0; i++) begin
            @(negedge clk);
            if (pwm_hs[0]) found = 1;
        end
        pulse_len(l2);
        check("R8", "pulse after wrap", l2, 8);
        @(posedge clk); #1;

        // R9: fault and stop
        repeat (3) step();
        fault = 1'b1;
        @(negedge clk);
        check("R9", "hs on fault", int'(pwm_hs), 0);
        check("R9", "ls on fault", int'(pwm_ls), 0);
        check("R9", "tick on fault", int'(tick_out), 0);
        @(posedge clk); #1;
        repeat (4) step();
        @(negedge clk);
        check("R9", "ls held fault", int'(pwm_ls), 0);
        @(posedge clk); #1;
        fault = 1'b0;
        @(negedge clk);
        check("R9", "hs0 first cycle after fault", int'(pwm_hs[0]), 0);
        check("R9", "ls0 first cycle after fault", int'(pwm_ls[0]), 1);
        @(negedge clk);
        check("R9", "hs0 restart from zero", int'(pwm_hs[0]), 1);
        check("R9", "ls1 running", int'(pwm_ls[1]), 1);
        @(posedge clk); #1;
        wr(ADR_CTRL, 32'd0);
        @(negedge clk);
        check("R9", "ls after stop", int'(pwm_ls), 0);
        check("R9", "hs after stop", int'(pwm_hs), 0);

        $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end

endmodule